// File: doc/BRIEF.md
# Summed-Area Table Engine

This block turns a square matrix of unsigned integers into its summed-area table. Each output element holds the sum of every input element at or above its row and at or left of its column. A matrix arrives through a valid/ready handshake that behaves like a FIFO read port. The finished table appears on a registered output bank, and a single-cycle completion pulse marks it.

The engine never builds the whole sum tree in one cycle. It runs two identical passes. Each pass reads the working matrix transposed and replaces every row with its inclusive running sum, starting from zero. A bank of N adders, one per row, advances every row by one element per cycle. With the default N = 6, the table is complete after 12 compute cycles. The transpose costs no cycle, because it is only a change of read index. Sums wrap modulo 2^W.

Top module: `sat_engine`

## Requirements
- R1: While `rst` is high at a rising clock edge, the engine is put into idle. After that edge, `in_ready` is 1, `out_valid` is 0 and `out_data` is all zeros.
- R2: A matrix is accepted at a rising edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 for the 2*N cycles that follow the accepting edge, and is 1 again in the cycle in which `out_valid` is 1.
- R3: `out_valid` is 1 for exactly one cycle, starting at the 2*N-th rising edge after the accepting edge. It is never 1 at any other time.
- R4: When `out_valid` is 1, element (i,j) of `out_data` equals the sum of the input elements (a,b) with a <= i and b <= j. Element (r,c) of both `in_data` and `out_data` sits at bits [(r*N+c)*W +: W].
- R5: All additions wrap modulo 2^W, with no saturation and no overflow indication. For example, a matrix of all-ones words gives element (i,j) = -(i+1)(j+1) mod 2^W.
- R6: `in_valid` and `in_data` have no effect while `in_ready` is 0. The table that is reported belongs to the matrix present at the accepting edge.
- R7: `out_data` keeps its value in every cycle in which `out_valid` is 0.
- R8: While `in_valid` stays 0, nothing is accepted, `in_ready` stays 1 and no `out_valid` pulse appears.
- R9: A new matrix can be accepted at the edge that ends the `out_valid` cycle. Its table follows 2*N cycles later, with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input matrix present |
| in_ready | output | 1 | Engine idle, matrix will be taken |
| in_data | input | N*N*W | Input matrix, row-major |
| out_valid | output | 1 | One-cycle pulse, table just written |
| out_data | output | N*N*W | Registered summed-area table, row-major |

## Verification
All results depend on the accepting edge. `in_ready` drops one edge after acceptance and comes back 2*N edges later. The `out_valid` pulse and the new `out_data` appear together on that same 2*N-th edge. The bench keeps a behavioural model that is stepped at every rising edge, using only its own record of whether the engine is busy. At each falling edge the model's expected handshake flag, pulse and table are compared with the ports, so every cycle of every latency is checked where it falls. The bench builds the expected table from an inclusion-exclusion recurrence rather than from passes.

// File: rtl/sat_engine.sv
module sat_engine #(
  parameter int N = 6,
  parameter int W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [N*N*W-1:0] in_data,
  output logic             out_valid,
  output logic [N*N*W-1:0] out_data
);
  localparam int KW = (N > 1) ? $clog2(N) : 1;
  localparam logic [KW-1:0] KLAST = KW'(N - 1);

  logic [W-1:0] src   [N][N];
  logic [W-1:0] dst   [N][N];
  logic [W-1:0] dst_n [N][N];
  logic [W-1:0] acc   [N];
  logic [W-1:0] sum   [N];
  logic [N*N*W-1:0] done_vec;
  logic busy, pass;
  logic [KW-1:0] k;

  assign in_ready = !busy;

  for (genvar r = 0; r < N; r++) begin : g_add
    assign sum[r] = ((k == '0) ? '0 : acc[r]) + src[k][r];
  end

  always_comb begin
    dst_n = dst;
    for (int r = 0; r < N; r++) dst_n[r][k] = sum[r];
  end

  for (genvar r = 0; r < N; r++) begin : g_pr
    for (genvar c = 0; c < N; c++) begin : g_pc
      assign done_vec[(r*N+c)*W +: W] = dst_n[r][c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      pass      <= 1'b0;
      k         <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= 1'b0;
      if (!busy) begin
        if (in_valid) begin
          busy <= 1'b1;
          pass <= 1'b0;
          k    <= '0;
          for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++)
              src[r][c] <= in_data[(r*N+c)*W +: W];
        end
      end else begin
        for (int r = 0; r < N; r++) begin
          dst[r][k] <= sum[r];
          acc[r]    <= sum[r];
        end
        if (k == KLAST) begin
          k <= '0;
          if (!pass) begin
            pass <= 1'b1;
            src  <= dst_n;
          end else begin
            busy      <= 1'b0;
            out_valid <= 1'b1;
            out_data  <= done_vec;
          end
        end else begin
          k <= k + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sat_engine_chk.sv
module sat_engine_chk #(
  parameter int N = 6,
  parameter int W = 64
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic [N*N*W-1:0] out_data
);
  localparam int CW = $clog2(2*N + 1);
  logic          run;
  logic [CW-1:0] cnt;
  wire           take = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (take) begin
      run <= 1'b1;
      cnt <= '0;
    end else if (run && cnt == CW'(2*N)) begin
      run <= 1'b0;
    end else if (run) begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> in_ready && !out_valid && out_data == '0); // R1
  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (rst) take |=> !in_ready); // R2
  AST_BUSY_WINDOW: assert property (@(posedge clk) disable iff (rst) (run && cnt < CW'(2*N)) |-> !in_ready); // R2
  AST_DONE_TIME: assert property (@(posedge clk) disable iff (rst) out_valid |-> run && cnt == CW'(2*N)); // R3
  AST_DONE_DUE: assert property (@(posedge clk) disable iff (rst) (run && cnt == CW'(2*N)) |-> out_valid && in_ready); // R9
  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (rst) out_valid |=> !out_valid); // R3
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst) (!out_valid && !$rose(run) && run) |-> $stable(out_data)); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst) (!run && !in_valid) |=> in_ready && !out_valid); // R8
endmodule

bind sat_engine sat_engine_chk #(.N(N), .W(W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_data(out_data)
);

// File: tb/test_sat_engine.sv
module test_sat_engine;
  localparam int N = 6;
  localparam int W = 64;
  localparam int MW = N*N*W;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0;
  logic [MW-1:0] in_data = '0;
  logic in_ready, out_valid;
  logic [MW-1:0] out_data;

  sat_engine #(.N(N), .W(W)) i_sat_engine (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int tests = 0, fails = 0, cyc = 0;
  string tag = "R4";

  // behavioural reference
  logic m_busy = 1'b0, m_valid = 1'b0;
  int m_cnt = 0;
  logic [MW-1:0] m_out = '0, m_pend = '0;

  function automatic logic [MW-1:0] sat_of(input logic [MW-1:0] m);
    logic [W-1:0] t [N][N];
    logic [MW-1:0] v;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        t[i][j] = m[(i*N+j)*W +: W];
        if (i > 0) t[i][j] += t[i-1][j];
        if (j > 0) t[i][j] += t[i][j-1];
        if (i > 0 && j > 0) t[i][j] -= t[i-1][j-1];
        v[(i*N+j)*W +: W] = t[i][j];
      end
    return v;
  endfunction

  function automatic logic [MW-1:0] gen(input int seed);
    logic [MW-1:0] v;
    for (int e = 0; e < N*N; e++)
      v[e*W +: W] = (64'(seed) * 64'h9E37_79B9_7F4A_7C15) ^ (64'(e) << (e % 50)) ^ 64'(e*131 + seed);
    return v;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      m_busy = 1'b0; m_cnt = 0; m_valid = 1'b0; m_out = '0;
    end else begin
      m_valid = 1'b0;
      if (!m_busy) begin
        if (in_valid) begin
          m_busy = 1'b1; m_cnt = 0; m_pend = sat_of(in_data);
        end
      end else begin
        m_cnt++;
        if (m_cnt == 2*N) begin
          m_busy = 1'b0; m_valid = 1'b1; m_out = m_pend;
        end
      end
    end
  end

  task automatic check1(input string req, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %0b expected %0b", req, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      check1("R2 in_ready", in_ready, !m_busy);
      check1("R3 out_valid", out_valid, m_valid);
      tests++;
      if (out_data !== m_out) begin
        fails++;
        $display("FAIL %s cycle %0d: actual %h expected %h",
                 m_valid ? tag : "R7", cyc, out_data, m_out);
      end
    end
  end

  task automatic send(input logic [MW-1:0] m);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_data = m;
    @(negedge clk);
    in_valid = 1'b0; in_data = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check1("R1 in_ready", in_ready, 1'b1);
    check1("R1 out_valid", out_valid, 1'b0);
    tests++;
    if (out_data !== '0) begin
      fails++;
      $display("FAIL R1 out_data: actual %h expected 0", out_data);
    end
    rst = 1'b0;
    // R8: no input, no activity
    idle(20);
    tag = "R4 ramp";
    begin
      logic [MW-1:0] v;
      for (int e = 0; e < N*N; e++) v[e*W +: W] = 64'(e + 1);
      send(v);
    end
    idle(2*N + 3);
    tag = "R4 mixed";
    send(gen(7));
    idle(2*N + 3);
    tag = "R5 wrap";
    send('1);
    idle(2*N + 3);
    // R6 and R9: valid held high with changing data while busy
    tag = "R6/R9 held";
    @(negedge clk);
    in_valid = 1'b1; in_data = gen(11);
    @(negedge clk);
    for (int i = 0; i < 3*2*N + 2; i++) begin
      in_data = gen(100 + i);
      @(negedge clk);
    end
    in_valid = 1'b0; in_data = '0;
    idle(2*N + 3);
    // R1: reset in the middle of a computation
    tag = "R1 abort";
    send(gen(3));
    idle(4);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check1("R1 in_ready after abort", in_ready, 1'b1);
    check1("R1 out_valid after abort", out_valid, 1'b0);
    idle(2*N + 3);
    tag = "R4 single";
    begin
      logic [MW-1:0] v = '0;
      v[(2*N+3)*W +: W] = 64'd5;
      send(v);
    end
    idle(2*N + 3);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule